// File: doc/BRIEF.md
# Core-Private Real-Time Tick Timer

This block keeps a free-running 64-bit time base for a processor core together with a 64-bit threshold. Both values sit behind a small 32-bit register port, one word per address, so software can load, preset or sample them one half at a time. The time base advances by one on every cycle in which a slow real-time-clock enable is high. The enable is assumed to be synchronous to the always-on clock that drives this block.

The block drives a level interrupt that stays high for as long as the time base is at or above the threshold. Two inputs can freeze the count. The first is raised by the core while it runs code injected by a debugger, so debug sessions do not disturb program-visible time. The second is a power-saving stop bit that software controls. Writes from the register port always win over a pending advance.

Top module: `core_tick_timer`

## Requirements
- R1: Once reset is released, the count reads 0, the threshold reads all ones (0xFFFFFFFF in both halves), and `timer_irq` is low.
- R2: Register words are chosen by `reg_addr[3:2]`: 0 = count bits 31:0, 1 = count bits 63:32, 2 = threshold bits 31:0, 3 = threshold bits 63:32. `reg_addr[1:0]` is ignored. A read request (`reg_sel`=1, `reg_wr`=0) returns the word on `reg_rdata` in the cycle after the request, and `reg_rdata` holds that value until the next read.
- R3: In each cycle with `rtc_tick`=1, `dbg_halt`=0 and `cnt_inhibit`=0, the count increases by exactly one. With `rtc_tick`=0 the count does not change.
- R4: A carry out of count bits 31:0 increments bits 63:32 in the same tick.
- R5: While `dbg_halt`=1, ticks leave the count unchanged.
- R6: While `cnt_inhibit`=1, ticks leave the count unchanged.
- R7: `timer_irq` is 1 in the cycle after the one in which count ≥ threshold (unsigned, 64 bits), and 0 in the cycle after the one in which count < threshold.
- R8: When a count half is written in the same cycle as a tick, the written half takes the written data. The other half takes its value from the incremented count.
- R9: Writing one half of the count or threshold leaves the other half unchanged.
- R10: Writing the threshold does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| rtc_tick | input | 1 | Real-time-clock enable, one count step per high cycle |
| dbg_halt | input | 1 | Core is executing debugger-injected code; freezes the count |
| cnt_inhibit | input | 1 | Software stop bit; freezes the count |
| reg_sel | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| timer_irq | output | 1 | Timer interrupt level |

## Verification
The bench builds the block with its default sizes: a 64-bit count made of two 32-bit words. These sizes let the bench preset the low word to all ones, so one tick crosses the word boundary and the carry path is exercised. The threshold comparison is tested at the exact boundary. Preset writes also make it cheap to drive a tick and a count-half write into the same cycle, so both precedence outcomes can be checked.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
  // register bank selected by the top word-index bit
  typedef enum logic {
    BANK_COUNT  = 1'b0,
    BANK_THRESH = 1'b1
  } bank_e;

  localparam int unsigned BYTE_BITS = 2;
endpackage

// File: rtl/ctt_rst_sync.sv
module ctt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ctt_regif.sv
module ctt_regif
  import ctt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NWORD  = 2,
  parameter int WSEL_W = 1,
  parameter int ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel,
  input  logic                      wr,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NWORD*DATA_W-1:0]   count,
  input  logic [NWORD*DATA_W-1:0]   thresh,
  output logic [NWORD-1:0]          cnt_we,
  output logic [NWORD-1:0]          thr_we,
  output logic [DATA_W-1:0]         rdata
);
  logic [WSEL_W-1:0] word_idx;
  bank_e             bank;
  logic [DATA_W-1:0] rd_mux;
  logic              rd_en;
  logic              byte_unused;

  assign word_idx    = addr[WSEL_W+BYTE_BITS-1:BYTE_BITS];
  assign bank        = bank_e'(addr[WSEL_W+BYTE_BITS]);
  assign byte_unused = ^addr[BYTE_BITS-1:0];
  assign rd_en       = sel & ~wr;

  always_comb begin
    cnt_we = '0;
    thr_we = '0;
    rd_mux = '0;
    for (int k = 0; k < NWORD; k++) begin
      if (word_idx == WSEL_W'(k)) begin
        cnt_we[k] = sel & wr & (bank == BANK_COUNT);
        thr_we[k] = sel & wr & (bank == BANK_THRESH);
        rd_mux    = (bank == BANK_THRESH) ? thresh[k*DATA_W +: DATA_W]
                                          : count[k*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/ctt_counter.sv
module ctt_counter #(
  parameter int DATA_W = 32,
  parameter int NWORD  = 2,
  localparam int CNT_W = NWORD*DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              halt,
  input  logic              inhibit,
  input  logic [NWORD-1:0]  we,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  count
);
  logic             adv;
  logic             cnt_ce;
  logic [CNT_W-1:0] cnt_d;

  assign adv    = tick & ~halt & ~inhibit;
  assign cnt_ce = adv | (|we);

  always_comb begin
    cnt_d = adv ? count + CNT_W'(1) : count;
    for (int k = 0; k < NWORD; k++) begin
      if (we[k]) cnt_d[k*DATA_W +: DATA_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_ce) count <= cnt_d;
  end

  // R5: debug execution freezes the count unless software writes it
  assert_halt_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && we == '0) |=> $stable(count));

  // R6: inhibit freezes the count unless software writes it
  assert_inhibit_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && we == '0) |=> $stable(count));

  // R3: no tick, no write, no change
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && we == '0) |=> $stable(count));
endmodule

// File: rtl/ctt_compare.sv
module ctt_compare #(
  parameter int DATA_W = 32,
  parameter int NWORD  = 2,
  localparam int CNT_W = NWORD*DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NWORD-1:0]  we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  thresh,
  output logic              irq
);
  logic [CNT_W-1:0] thr_d;
  logic             thr_ce;
  logic             irq_d;

  assign thr_ce = |we;
  assign irq_d  = (count >= thresh);

  always_comb begin
    thr_d = thresh;
    for (int k = 0; k < NWORD; k++) begin
      if (we[k]) thr_d[k*DATA_W +: DATA_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thresh <= '1;
    else if (thr_ce) thresh <= thr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  // R7: a rising interrupt follows a count at or past the threshold
  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(count) >= $past(thresh));

  // R9: untouched threshold halves keep their value
  assert_thr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we == '0) |=> $stable(thresh));
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer #(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 64,
  localparam int NWORD  = CNT_W / DATA_W,
  localparam int WSEL_W = $clog2(NWORD),
  localparam int ADDR_W = WSEL_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rtc_tick,
  input  logic              dbg_halt,
  input  logic              cnt_inhibit,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              timer_irq
);
  logic             rst_sync_n;
  logic [NWORD-1:0] cnt_we;
  logic [NWORD-1:0] thr_we;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] thresh;

  ctt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ctt_regif #(
    .DATA_W (DATA_W), .NWORD (NWORD), .WSEL_W (WSEL_W), .ADDR_W (ADDR_W)
  ) u_regif (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sel    (reg_sel),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .count  (count),
    .thresh (thresh),
    .cnt_we (cnt_we),
    .thr_we (thr_we),
    .rdata  (reg_rdata)
  );

  ctt_counter #(.DATA_W (DATA_W), .NWORD (NWORD)) u_counter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (rtc_tick),
    .halt    (dbg_halt),
    .inhibit (cnt_inhibit),
    .we      (cnt_we),
    .wdata   (reg_wdata),
    .count   (count)
  );

  ctt_compare #(.DATA_W (DATA_W), .NWORD (NWORD)) u_compare (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (thr_we),
    .wdata  (reg_wdata),
    .count  (count),
    .thresh (thresh),
    .irq    (timer_irq)
  );

  // R3 and R4: a free tick steps the full-width count by one, carry included
  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rtc_tick && !dbg_halt && !cnt_inhibit && cnt_we == '0)
      |=> count == $past(count) + CNT_W'(1));

  // R10: threshold writes never disturb the count
  assert_thr_wr_isolated_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (thr_we != '0 && !rtc_tick) |=> $stable(count));

  // R2: at most one word is written per access
  assert_single_word_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({cnt_we, thr_we}));

  generate
    for (genvar g = 0; g < NWORD; g++) begin : g_wr_chk
      // R8: a written count half takes the bus data even on a tick
      assert_wr_wins_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
        cnt_we[g] |=> count[g*DATA_W +: DATA_W] == $past(reg_wdata));
    end
  endgenerate
endmodule

// File: tb/test_core_tick_timer.sv
module test_core_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rtc_tick, dbg_halt, cnt_inhibit;
  logic        reg_sel, reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        timer_irq;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  core_tick_timer i_core_tick_timer (
    .clk (clk), .rst_n (rst_n), .rtc_tick (rtc_tick), .dbg_halt (dbg_halt),
    .cnt_inhibit (cnt_inhibit), .reg_sel (reg_sel), .reg_wr (reg_wr),
    .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .timer_irq (timer_irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d, input logic with_tick);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d; rtc_tick = with_tick;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; rtc_tick = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_sel = 1'b0;
    d = reg_rdata;
  endtask

  task automatic read_count(output logic [63:0] v);
    logic [31:0] lo, hi;
    bus_read(4'h0, lo);
    bus_read(4'h4, hi);
    v = {hi, lo};
  endtask

  task automatic set_count(input logic [63:0] v);
    bus_write(4'h4, v[63:32], 1'b0);
    bus_write(4'h0, v[31:0], 1'b0);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rtc_tick = 1'b1;
      @(negedge clk); rtc_tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq after reset", {63'd0, timer_irq}, 64'd0);
    bus_read(4'h0, d); check("R1 count low", {32'd0, d}, 64'd0);
    bus_read(4'h4, d); check("R1 count high", {32'd0, d}, 64'd0);
    bus_read(4'h8, d); check("R1 thresh low", {32'd0, d}, 64'hFFFF_FFFF);
    bus_read(4'hC, d); check("R1 thresh high", {32'd0, d}, 64'hFFFF_FFFF);
  endtask

  task automatic t_map;
    logic [31:0] d;
    bus_write(4'h9, 32'h1122_3344, 1'b0);  // byte bits ignored
    bus_write(4'hE, 32'h5566_7788, 1'b0);
    bus_write(4'h0, 32'hA0A0_0001, 1'b0);
    bus_write(4'h7, 32'h0B0B_0002, 1'b0);
    bus_read(4'h8, d); check("R2 thresh low word", {32'd0, d}, 64'h1122_3344);
    bus_read(4'hD, d); check("R2 thresh high word", {32'd0, d}, 64'h5566_7788);
    bus_read(4'h3, d); check("R2 count low word", {32'd0, d}, 64'hA0A0_0001);
    bus_read(4'h4, d); check("R2 count high word", {32'd0, d}, 64'h0B0B_0002);
    repeat (2) @(negedge clk);
    check("R2 rdata holds between reads", {32'd0, reg_rdata}, 64'h0B0B_0002);
  endtask

  task automatic t_halfwrite;
    logic [31:0] d;
    bus_write(4'h8, 32'hDEAD_0000, 1'b0);
    bus_read(4'hC, d); check("R9 thresh high untouched", {32'd0, d}, 64'h5566_7788);
    bus_write(4'h4, 32'h0000_0077, 1'b0);
    bus_read(4'h0, d); check("R9 count low untouched", {32'd0, d}, 64'hA0A0_0001);
    bus_read(4'h4, d); check("R10 count high after thresh write", {32'd0, d}, 64'h77);
  endtask

  task automatic t_count;
    logic [63:0] v;
    set_count(64'd100);
    tick_n(7);
    read_count(v); check("R3 seven ticks", v, 64'd107);
    repeat (10) @(negedge clk);
    read_count(v); check("R3 no tick holds", v, 64'd107);
  endtask

  task automatic t_carry;
    logic [63:0] v;
    set_count({32'd5, 32'hFFFF_FFFF});
    tick_n(1);
    read_count(v); check("R4 carry into high word", v, {32'd6, 32'd0});
  endtask

  task automatic t_freeze;
    logic [63:0] v;
    set_count(64'd50);
    dbg_halt = 1'b1; tick_n(5); dbg_halt = 1'b0;
    read_count(v); check("R5 debug halt freezes", v, 64'd50);
    cnt_inhibit = 1'b1; tick_n(4); cnt_inhibit = 1'b0;
    read_count(v); check("R6 inhibit freezes", v, 64'd50);
    tick_n(2);
    read_count(v); check("R3 resumes after freeze", v, 64'd52);
  endtask

  task automatic t_precedence;
    logic [63:0] v;
    set_count({32'd3, 32'd10});
    bus_write(4'h0, 32'h0000_0100, 1'b1);
    read_count(v); check("R8 low write wins over tick", v, {32'd3, 32'h100});
    bus_write(4'h4, 32'd9, 1'b1);
    read_count(v); check("R8 high write, low still ticks", v, {32'd9, 32'h101});
  endtask

  task automatic t_irq;
    set_count(64'd0);
    bus_write(4'hC, 32'd0, 1'b0);
    bus_write(4'h8, 32'd10, 1'b0);
    tick_n(9);
    @(negedge clk);
    check("R7 below threshold low", {63'd0, timer_irq}, 64'd0);
    @(negedge clk); rtc_tick = 1'b1;
    @(negedge clk); rtc_tick = 1'b0;
    check("R7 one-cycle lag at equality", {63'd0, timer_irq}, 64'd0);
    @(negedge clk);
    check("R7 equal raises irq", {63'd0, timer_irq}, 64'd1);
    tick_n(3);
    check("R7 above threshold high", {63'd0, timer_irq}, 64'd1);
    bus_write(4'h8, 32'd20, 1'b0);
    @(negedge clk);
    check("R7 raised threshold clears irq", {63'd0, timer_irq}, 64'd0);
    bus_write(4'hC, 32'd1, 1'b0);
    bus_write(4'h8, 32'd0, 1'b0);
    set_count({32'd1, 32'd0});
    @(negedge clk);
    check("R7 64-bit compare via high word", {63'd0, timer_irq}, 64'd1);
  endtask

  initial begin
    rst_n = 1'b0; rtc_tick = 0; dbg_halt = 0; cnt_inhibit = 0;
    reg_sel = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_map;
    t_halfwrite;
    t_count;
    t_carry;
    t_freeze;
    t_precedence;
    t_irq;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule